// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns the addressing fields of a load or store into the address that goes to the memory port. It also produces the value that the base register should hold after the access, and a flag that says whether that value is to be written back. The offset added to the base comes from one of three sources: a short unsigned constant, a full register operand, or a register operand that first passes through a barrel shifter controlled by a constant amount. A single flag selects whether that offset is added or subtracted. The arithmetic wraps modulo 2^32.

Three indexing modes exist. In plain offset mode the access uses base plus or minus offset and leaves the base alone. In pre-index mode it uses the same sum and also returns it as the new base. In post-index mode it accesses the untouched base and returns the sum as the new base. Write-back only happens when the instruction's condition is met. The block has one register stage: a request presented with `in_valid` in one cycle has its result on the outputs after the next rising clock edge.

Top module: `agu_top`

## Requirements
- R1: After synchronous reset, `out_valid`, `wb_en`, `mem_addr` and `new_base` are all zero.
- R2: `ofs_kind` selects the offset: 0 gives `imm_ofs` zero-extended to 32 bits, 1 gives `reg_ofs` unchanged, and 2 or 3 give `reg_ofs` after the shift set by `sh_kind` and `sh_amt`.
- R3: The shift encodings are 0 = logical left, 1 = logical right, 2 = arithmetic right (sign fill), 3 = rotate right. `sh_amt` ranges from 0 to 31, and an amount of 0 leaves the operand unshifted for every type.
- R4: With `subtract` = 0 the sum is base + offset, and with `subtract` = 1 it is base - offset. Both wrap modulo 2^32. For example, 0x200 + 12 = 0x20C, and 0x4 - 8 = 0xFFFFFFFC.
- R5: In offset mode (`idx_mode` = 0), `mem_addr` is the sum, `new_base` equals the incoming base, and `wb_en` is 0.
- R6: In pre-index mode (`idx_mode` = 1), `mem_addr` and `new_base` both equal the sum, and `wb_en` equals `cond_pass`.
- R7: In post-index mode (`idx_mode` = 2), `mem_addr` is the unmodified base, `new_base` is the sum, and `wb_en` equals `cond_pass`.
- R8: `idx_mode` = 3 is reserved and behaves exactly like offset mode.
- R9: When `cond_pass` is 0, `wb_en` is 0 whatever the mode. The address and new base are still formed as usual.
- R10: Results appear one clock after the request. `out_valid` follows `in_valid` with one cycle of delay, and `wb_en` is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| base | input | 32 | Base register value |
| imm_ofs | input | 12 | Unsigned immediate offset |
| reg_ofs | input | 32 | Register offset operand |
| ofs_kind | input | 2 | Offset source select |
| sh_kind | input | 2 | Shift type for the scaled offset |
| sh_amt | input | 5 | Constant shift amount |
| subtract | input | 1 | 1 = subtract offset, 0 = add |
| idx_mode | input | 2 | Indexing mode |
| cond_pass | input | 1 | Instruction condition met |
| out_valid | output | 1 | Result valid |
| mem_addr | output | 32 | Effective memory address |
| new_base | output | 32 | Base value after the access |
| wb_en | output | 1 | Write new_base back to the base register |

## Verification
The bench aims at places where a small slip still gives plausible addresses:
- If post-index mode is swapped with pre-index mode, the access goes to the updated address instead of the original base.
- If arithmetic and logical right shifts are confused, negative register offsets come out wrong.
- If the rotate drops its wrapped bits, low bits are lost.
- If the arithmetic saturates or carries into a 33rd bit, sums near 0xFFFFFFFF and differences below zero come out wrong.
- If the condition gate or the reserved mode is mishandled, a write-back enable appears where none belongs.

Random requests, using a fixed seed, cover the mix of modes and offset kinds. Directed cases pin down the 0x200 + 12 example, both wrap directions and an idle cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int unsigned AGU_W = 32;
    localparam int unsigned IMM_W = 12;
    localparam int unsigned SH_W  = $clog2(AGU_W);

    typedef enum logic [1:0] {
        OFS_IMM     = 2'd0,
        OFS_REG     = 2'd1,
        OFS_SCALED  = 2'd2,
        OFS_SCALED2 = 2'd3
    } ofs_kind_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        IDX_OFFSET = 2'd0,
        IDX_PRE    = 2'd1,
        IDX_POST   = 2'd2,
        IDX_RSVD   = 2'd3
    } idx_mode_e;

    typedef struct packed {
        logic [AGU_W-1:0] addr;
        logic [AGU_W-1:0] base_next;
        logic             wb;
    } agu_result_t;

    // One fixed-distance step of the barrel shifter.
    function automatic logic [AGU_W-1:0] shift_step(
        input logic [AGU_W-1:0] v,
        input shift_kind_e      k,
        input int unsigned      n
    );
        logic [2*AGU_W-1:0] dbl;
        dbl = {v, v} >> n;
        case (k)
            SH_LSL:  return v << n;
            SH_LSR:  return v >> n;
            SH_ASR:  return AGU_W'($signed(v) >>> n);
            default: return dbl[AGU_W-1:0];
        endcase
    endfunction

endpackage

// File: rtl/agu_shifter.sv
module agu_shifter
    import agu_pkg::*;
(
    input  logic [AGU_W-1:0] din,
    input  shift_kind_e      kind,
    input  logic [SH_W-1:0]  amt,
    output logic [AGU_W-1:0] dout
);
    logic [AGU_W-1:0] stg [SH_W+1];

    assign stg[0] = din;

    genvar s;
    generate
        for (s = 0; s < SH_W; s++) begin : g_stage
            localparam int unsigned DIST = 1 << s;
            assign stg[s+1] = amt[s] ? shift_step(stg[s], kind, DIST) : stg[s];
        end
    endgenerate

    assign dout = stg[SH_W];
endmodule

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
    import agu_pkg::*;
(
    input  logic [IMM_W-1:0] imm_ofs,
    input  logic [AGU_W-1:0] reg_ofs,
    input  ofs_kind_e        kind,
    input  shift_kind_e      sh_kind,
    input  logic [SH_W-1:0]  sh_amt,
    output logic [AGU_W-1:0] offset
);
    localparam int unsigned PAD_W = AGU_W - IMM_W;

    logic [AGU_W-1:0] shifted;

    agu_shifter u_shifter (
        .din  (reg_ofs),
        .kind (sh_kind),
        .amt  (sh_amt),
        .dout (shifted)
    );

    always_comb begin
        case (kind)
            OFS_IMM: offset = {{PAD_W{1'b0}}, imm_ofs};
            OFS_REG: offset = reg_ofs;
            default: offset = shifted;
        endcase
    end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub
    import agu_pkg::*;
(
    input  logic [AGU_W-1:0] base,
    input  logic [AGU_W-1:0] offset,
    input  logic             subtract,
    output logic [AGU_W-1:0] sum
);
    // Two's complement subtract: base + ~offset + 1, carry out discarded.
    logic [AGU_W-1:0] operand;
    assign operand = subtract ? ~offset : offset;
    assign sum     = base + operand + {{(AGU_W-1){1'b0}}, subtract};
endmodule

// File: rtl/agu_mode_ctl.sv
module agu_mode_ctl
    import agu_pkg::*;
(
    input  idx_mode_e        mode,
    input  logic [AGU_W-1:0] base,
    input  logic [AGU_W-1:0] sum,
    input  logic             cond_pass,
    output agu_result_t      res
);
    always_comb begin
        res.addr      = sum;
        res.base_next = base;
        res.wb        = 1'b0;
        case (mode)
            IDX_PRE: begin
                res.base_next = sum;
                res.wb        = cond_pass;
            end
            IDX_POST: begin
                res.addr      = base;
                res.base_next = sum;
                res.wb        = cond_pass;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] base,
    input  logic [11:0] imm_ofs,
    input  logic [31:0] reg_ofs,
    input  logic [1:0]  ofs_kind,
    input  logic [1:0]  sh_kind,
    input  logic [4:0]  sh_amt,
    input  logic        subtract,
    input  logic [1:0]  idx_mode,
    input  logic        cond_pass,
    output logic        out_valid,
    output logic [31:0] mem_addr,
    output logic [31:0] new_base,
    output logic        wb_en
);
    logic [AGU_W-1:0] offset;
    logic [AGU_W-1:0] sum;
    agu_result_t      res;
    agu_result_t      res_q;
    logic             vld_q;

    agu_offset_sel u_ofs (
        .imm_ofs (imm_ofs),
        .reg_ofs (reg_ofs),
        .kind    (ofs_kind_e'(ofs_kind)),
        .sh_kind (shift_kind_e'(sh_kind)),
        .sh_amt  (sh_amt),
        .offset  (offset)
    );

    agu_addsub u_add (
        .base     (base),
        .offset   (offset),
        .subtract (subtract),
        .sum      (sum)
    );

    agu_mode_ctl u_mode (
        .mode      (idx_mode_e'(idx_mode)),
        .base      (base),
        .sum       (sum),
        .cond_pass (cond_pass),
        .res       (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res;
            end else begin
                res_q.wb <= 1'b0;
            end
        end
    end

    assign out_valid = vld_q;
    assign mem_addr  = res_q.addr;
    assign new_base  = res_q.base_next;
    assign wb_en     = res_q.wb;
endmodule

// File: rtl/agu_chk.sv
module agu_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] base,
    input logic [11:0] imm_ofs,
    input logic [31:0] reg_ofs,
    input logic [1:0]  ofs_kind,
    input logic [1:0]  sh_kind,
    input logic [4:0]  sh_amt,
    input logic        subtract,
    input logic [1:0]  idx_mode,
    input logic        cond_pass,
    input logic        out_valid,
    input logic [31:0] mem_addr,
    input logic [31:0] new_base,
    input logic        wb_en
);
    // R10
    wb_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> out_valid);

    // R9
    cond_fail_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cond_pass) |=> !wb_en);

    // R5
    offset_keeps_base_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && idx_mode == 2'd0) |=> (!wb_en && new_base == $past(base)));

    // R7
    post_uses_base_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && idx_mode == 2'd2) |=> (mem_addr == $past(base)));

    // R6
    pre_addr_matches_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && idx_mode == 2'd1) |=> (new_base == mem_addr));

    // R2
    imm_add_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ofs_kind == 2'd0 && !subtract && idx_mode != 2'd2)
        |=> (mem_addr == $past(base) + {20'd0, $past(imm_ofs)}));
endmodule

bind agu_top agu_chk u_chk (.*);

// File: tb/agu_top_tb.sv
module agu_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] base;
    logic [11:0] imm_ofs;
    logic [31:0] reg_ofs;
    logic [1:0]  ofs_kind;
    logic [1:0]  sh_kind;
    logic [4:0]  sh_amt;
    logic        subtract;
    logic [1:0]  idx_mode;
    logic        cond_pass;
    logic        out_valid;
    logic [31:0] mem_addr;
    logic [31:0] new_base;
    logic        wb_en;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    agu_top u_dut (.*);

    function automatic logic [31:0] ref_shift(input logic [31:0] v, input logic [1:0] k,
                                              input logic [4:0] a);
        logic [63:0] d;
        d = {v, v} >> a;
        case (k)
            2'd0:    return v << a;
            2'd1:    return v >> a;
            2'd2:    return 32'($signed(v) >>> a);
            default: return d[31:0];
        endcase
    endfunction

    function automatic logic [31:0] ref_off(input logic [1:0] kind, input logic [11:0] imm,
                                            input logic [31:0] r, input logic [1:0] k,
                                            input logic [4:0] a);
        if (kind == 2'd0) return {20'd0, imm};
        if (kind == 2'd1) return r;
        return ref_shift(r, k, a);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [31:0] b, input logic [11:0] im,
                         input logic [31:0] r, input logic [1:0] kd, input logic [1:0] sk,
                         input logic [4:0] sa, input logic sub, input logic [1:0] md,
                         input logic cp);
        logic [31:0] off, sum, e_addr, e_nb;
        logic        e_wb;
        off = ref_off(kd, im, r, sk, sa);
        sum = sub ? b - off : b + off;
        case (md)
            2'd1:    begin e_addr = sum; e_nb = sum; e_wb = cp;   end
            2'd2:    begin e_addr = b;   e_nb = sum; e_wb = cp;   end
            default: begin e_addr = sum; e_nb = b;   e_wb = 1'b0; end
        endcase
        in_valid = 1'b1; base = b; imm_ofs = im; reg_ofs = r; ofs_kind = kd;
        sh_kind = sk; sh_amt = sa; subtract = sub; idx_mode = md; cond_pass = cp;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", {31'd0, out_valid}, 32'd1);
        check(req, "mem_addr", mem_addr, e_addr);
        check(req, "new_base", new_base, e_nb);
        check(req, "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; base = '0; imm_ofs = '0; reg_ofs = '0;
        ofs_kind = '0; sh_kind = '0; sh_amt = '0; subtract = 1'b0;
        idx_mode = '0; cond_pass = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R1", "wb_en", {31'd0, wb_en}, 32'd0);
        check("R1", "mem_addr", mem_addr, 32'd0);
        check("R1", "new_base", new_base, 32'd0);
        rst = 1'b0;

        // R7 post-index, 0x200 + 12
        apply("R7", 32'h200, 12'd12, 32'd0, 2'd0, 2'd0, 5'd0, 1'b0, 2'd2, 1'b1);
        // R6 pre-index, 0x200 + 12
        apply("R6", 32'h200, 12'd12, 32'd0, 2'd0, 2'd0, 5'd0, 1'b0, 2'd1, 1'b1);
        // R5 offset mode, register offset
        apply("R5", 32'h1000, 12'd0, 32'h34, 2'd1, 2'd0, 5'd0, 1'b0, 2'd0, 1'b1);
        // R4 wrap upward and downward
        apply("R4", 32'hFFFF_FFF0, 12'h020, 32'd0, 2'd0, 2'd0, 5'd0, 1'b0, 2'd1, 1'b1);
        apply("R4", 32'h4, 12'd8, 32'd0, 2'd0, 2'd0, 5'd0, 1'b1, 2'd0, 1'b1);
        // R3 arithmetic right shift of a negative operand
        apply("R3", 32'h8000, 12'd0, 32'h8000_0000, 2'd2, 2'd2, 5'd4, 1'b0, 2'd0, 1'b1);
        // R3 rotate right keeps wrapped bits
        apply("R3", 32'h0, 12'd0, 32'h0000_00F1, 2'd3, 2'd3, 5'd4, 1'b0, 2'd0, 1'b1);
        // R3 logical left by 2, subtracted
        apply("R3", 32'h100, 12'd0, 32'h10, 2'd2, 2'd0, 5'd2, 1'b1, 2'd1, 1'b1);
        // R2 immediate at its largest value
        apply("R2", 32'h0, 12'hFFF, 32'hDEAD_BEEF, 2'd0, 2'd1, 5'd7, 1'b0, 2'd0, 1'b1);
        // R8 reserved mode acts as offset mode
        apply("R8", 32'h500, 12'd4, 32'd0, 2'd0, 2'd0, 5'd0, 1'b0, 2'd3, 1'b1);
        // R9 failed condition blocks write-back in pre and post modes
        apply("R9", 32'h200, 12'd12, 32'd0, 2'd0, 2'd0, 5'd0, 1'b0, 2'd1, 1'b0);
        apply("R9", 32'h200, 12'd12, 32'd0, 2'd0, 2'd0, 5'd0, 1'b0, 2'd2, 1'b0);

        // R10 idle cycle: no valid, no write-back
        @(posedge clk);
        @(negedge clk);
        check("R10", "out_valid idle", {31'd0, out_valid}, 32'd0);
        check("R10", "wb_en idle", {31'd0, wb_en}, 32'd0);

        // Random mix across all modes and offset kinds
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            logic [1:0] md;
            string      tag;
            md = 2'($urandom);
            case (md)
                2'd0:    tag = "R5";
                2'd1:    tag = "R6";
                2'd2:    tag = "R7";
                default: tag = "R8";
            endcase
            apply(tag, $urandom, 12'($urandom), $urandom, 2'($urandom), 2'($urandom),
                  5'($urandom), 1'($urandom), md, 1'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule